// File: doc/BRIEF.md
# Half-Width Multiply and Divide Unit

This block executes integer multiply and divide micro-operations on 64-bit register values at an operand size of 2, 4 or 8 bytes. A request names an operation, a size, a first source, and a second operand taken either from a second source register or from a zero-extended 8-bit immediate. The result covers only the low operand-size bits. It is merged into the old destination value supplied with the request, so the bits above the operand size keep their old value.

Multiplies finish in a fixed short time. Divides use a shift-subtract loop that produces one quotient bit per cycle, so they take as many cycles as the operand size has bits. A zero divisor is detected when the request is taken. It skips the loop, raises a divide-by-zero indication and hands back the old destination.

The controller has four states. IDLE waits for a request. MULT holds the one cycle that registers a product. DIVIDE runs the quotient loop. FINISH presents the result with the done strobe. The transitions are:

- take-mul: IDLE to MULT, on start with a multiply code.
- take-div: IDLE to DIVIDE, on start with a divide code and a non-zero divisor.
- div-zero: IDLE to FINISH, on start with a divide code and a zero divisor.
- mul-done: MULT to FINISH, always.
- last-bit: DIVIDE to FINISH, once the final quotient bit has been produced.
- retire: FINISH to IDLE, always.

Top module: `muldiv_unit`

## Requirements
- R1: The size code selects the operand size. Code 0 is 16 bits, code 1 is 32 bits, and codes 2 and 3 are 64 bits. The half-size is half the operand size. Both operands are masked to the operand size. When use_imm is 1, the second operand is the 8-bit immediate zero-extended; otherwise it is src_b.
- R2: Opcode 0 (unsigned half multiply) multiplies the low half-size bits of each operand as unsigned values.
- R3: Opcode 1 (signed half multiply) sign-extends each operand from bit half-size−1 and then multiplies.
- R4: Opcode 2 (low product) returns the low operand-size bits of the product of the two operands. Opcode 7 behaves the same way.
- R5: Opcode 3 (high product) computes the three partial-product terms from the high and low halves of each operand. The result is (lo1·hi2 >> half) + (hi1·lo2 >> half) + hi1·hi2.
- R6: Opcode 4 (packed divide) places the unsigned quotient, masked to half-size bits, in the low half of the result. It places the remainder, also masked to half-size bits, in the high half.
- R7: Opcode 5 returns the full unsigned quotient, and opcode 6 returns the full unsigned remainder, of the first operand divided by the second.
- R8: Every result replaces only the low operand-size bits of dest_in captured with the request. The bits above the operand size are returned unchanged.
- R9: done is high for exactly one cycle. For a multiply taken at clock edge k, done and the result appear after edge k+1. dest_out holds its value while done is low.
- R10: For a divide with a non-zero divisor taken at edge k, done and the result appear after edge k+N, where N is the operand size in bits.
- R11: A divide whose masked divisor is zero raises div_zero together with done after the same edge that took the request. The returned destination equals dest_in unchanged. div_zero is low at all other times.
- R12: A start pulse while a request is in progress is ignored, including in the cycle that shows done. Inputs changed during that time do not affect the result.
- R13: During reset, done and div_zero are 0 and dest_out is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| opcode | input | 3 | Operation code (see R2–R7) |
| size_code | input | 2 | Operand size code (see R1) |
| use_imm | input | 1 | Selects the immediate as second operand |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source register |
| imm | input | 8 | Immediate second operand |
| dest_in | input | 64 | Old destination value to merge into |
| dest_out | output | 64 | Merged result, valid with done |
| done | output | 1 | One-cycle completion strobe |
| div_zero | output | 1 | Divide-by-zero indication, valid with done |

## Verification
The bench builds the unit with its default 64-bit datapath and 8-bit immediate. All three operand sizes are therefore reachable, including the full 64-bit divide loop with its longest latency. The high-product and sign-extension paths are exercised at every half-size. Mixing immediates and register operands at the small sizes makes zero divisors and the masking of wide operands frequent. Repeated starts and changed inputs during a busy request probe the ignore rule at every state, including the done cycle.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_MULHU = 3'd0,
        OP_MULHS = 3'd1,
        OP_MULLO = 3'd2,
        OP_MULHI = 3'd3,
        OP_DIVPK = 3'd4,
        OP_DIVQ  = 3'd5,
        OP_DIVR  = 3'd6,
        OP_MULLA = 3'd7
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MULT   = 2'd1,
        ST_DIVIDE = 2'd2,
        ST_FINISH = 2'd3
    } mdu_state_e;

    function automatic logic is_div(input mdu_op_e op);
        return (op == OP_DIVPK) || (op == OP_DIVQ) || (op == OP_DIVR);
    endfunction

endpackage

// File: rtl/mdu_size_decode.sv
module mdu_size_decode #(
    parameter int XLEN  = 64,
    parameter int CNT_W = 7
) (
    input  logic [1:0]       size_code,
    output logic [CNT_W-1:0] nbits,
    output logic [CNT_W-1:0] half,
    output logic [XLEN-1:0]  nmask,
    output logic [XLEN-1:0]  hmask
);
    localparam int SMALL_W = XLEN / 4;
    localparam int MID_W   = XLEN / 2;

    always_comb begin
        unique case (size_code)
            2'd0:    nbits = CNT_W'(SMALL_W);
            2'd1:    nbits = CNT_W'(MID_W);
            default: nbits = CNT_W'(XLEN);
        endcase
        half  = nbits >> 1;
        nmask = (nbits == CNT_W'(XLEN)) ? '1 : ((XLEN'(1) << nbits) - XLEN'(1));
        hmask = (XLEN'(1) << half) - XLEN'(1);
    end
endmodule

// File: rtl/mdu_multiplier.sv
module mdu_multiplier
    import mdu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = 7
) (
    input  mdu_op_e          op,
    input  logic [CNT_W-1:0] half,
    input  logic [XLEN-1:0]  hmask,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic [XLEN-1:0]  prod
);
    localparam int IDX_W = $clog2(XLEN);

    logic [IDX_W-1:0] sign_idx;
    logic [XLEN-1:0]  a_lo, b_lo, a_hi, b_hi, a_sx, b_sx, upper;

    always_comb begin
        sign_idx = IDX_W'(half - CNT_W'(1));
        a_lo = opa & hmask;
        b_lo = opb & hmask;
        a_hi = opa >> half;
        b_hi = opb >> half;
        a_sx = a_lo | (opa[sign_idx] ? ~hmask : '0);
        b_sx = b_lo | (opb[sign_idx] ? ~hmask : '0);
        upper = ((a_lo * b_hi) >> half) + ((a_hi * b_lo) >> half) + (a_hi * b_hi);
        case (op)
            OP_MULHU: prod = a_lo * b_lo;
            OP_MULHS: prod = a_sx * b_sx;
            OP_MULHI: prod = upper;
            default:  prod = opa * opb;
        endcase
    end
endmodule

// File: rtl/mdu_div_step.sv
module mdu_div_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rem_i,
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] dvsr,
    output logic [XLEN-1:0] rem_o,
    output logic [XLEN-1:0] quo_o
);
    logic [XLEN:0] shifted;
    logic          fits;

    always_comb begin
        shifted = {rem_i, quo_i[XLEN-1]};
        fits    = shifted >= {1'b0, dvsr};
        rem_o   = fits ? XLEN'(shifted - {1'b0, dvsr}) : XLEN'(shifted);
        quo_o   = {quo_i[XLEN-2:0], fits};
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import mdu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       opcode,
    input  logic [1:0]       size_code,
    input  logic             use_imm,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  dest_in,
    output logic [XLEN-1:0]  dest_out,
    output logic             done,
    output logic             div_zero
);
    localparam int CNT_W = $clog2(XLEN + 1);

    mdu_state_e       state_q, state_d;
    mdu_op_e          op_in, op_q;
    logic [CNT_W-1:0] nbits_in, half_in, half_q, cnt_q;
    logic [XLEN-1:0]  nmask_in, hmask_in, nmask_q, hmask_q;
    logic [XLEN-1:0]  op2_raw, a_m, b_m;
    logic [XLEN-1:0]  a_q, b_q, old_q, rem_q, quo_q, rem_n, quo_n;
    logic [XLEN-1:0]  prod, div_word, raw, res_q;
    logic             div_req, zero_req, dz_q;

    mdu_size_decode #(.XLEN(XLEN), .CNT_W(CNT_W)) i_size (
        .size_code(size_code), .nbits(nbits_in), .half(half_in),
        .nmask(nmask_in), .hmask(hmask_in)
    );

    always_comb begin
        op_in    = mdu_op_e'(opcode);
        op2_raw  = use_imm ? {{(XLEN-IMM_W){1'b0}}, imm} : src_b;
        a_m      = src_a & nmask_in;
        b_m      = op2_raw & nmask_in;
        div_req  = is_div(op_in);
        zero_req = div_req && (b_m == '0);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = zero_req ? ST_FINISH : (div_req ? ST_DIVIDE : ST_MULT);
            ST_MULT:   state_d = ST_FINISH;
            ST_DIVIDE: if (cnt_q == CNT_W'(1)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture and quotient loop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_MULHU;
            a_q     <= '0;
            b_q     <= '0;
            old_q   <= '0;
            half_q  <= '0;
            hmask_q <= '0;
            nmask_q <= '0;
            cnt_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
        end else if (state_q == ST_IDLE && start) begin
            op_q    <= op_in;
            a_q     <= a_m;
            b_q     <= b_m;
            old_q   <= dest_in;
            half_q  <= half_in;
            hmask_q <= hmask_in;
            nmask_q <= nmask_in;
            cnt_q   <= nbits_in;
            rem_q   <= '0;
            quo_q   <= a_m << (CNT_W'(XLEN) - nbits_in);
        end else if (state_q == ST_DIVIDE) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    mdu_multiplier #(.XLEN(XLEN), .CNT_W(CNT_W)) i_mul (
        .op(op_q), .half(half_q), .hmask(hmask_q),
        .opa(a_q), .opb(b_q), .prod(prod)
    );

    mdu_div_step #(.XLEN(XLEN)) i_step (
        .rem_i(rem_q), .quo_i(quo_q), .dvsr(b_q),
        .rem_o(rem_n), .quo_o(quo_n)
    );

    always_comb begin
        case (op_q)
            OP_DIVPK: div_word = (quo_n & hmask_q) | ((rem_n & hmask_q) << half_q);
            OP_DIVQ:  div_word = quo_n;
            default:  div_word = rem_n;
        endcase
        raw = (state_q == ST_DIVIDE) ? div_word : prod;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            dz_q  <= 1'b0;
        end else begin
            dz_q <= (state_q == ST_IDLE) && (state_d == ST_FINISH);
            if (state_d == ST_FINISH)
                res_q <= (state_q == ST_IDLE) ? dest_in
                                              : ((old_q & ~nmask_q) | (raw & nmask_q));
        end
    end

    assign dest_out = res_q;
    assign div_zero = dz_q;
    assign done     = (state_q == ST_FINISH);

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
    import mdu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       done,
    input logic                       div_zero,
    input logic [XLEN-1:0]            dest_out,
    input mdu_state_e                 state,
    input logic [$clog2(XLEN+1)-1:0]  cnt
);
    localparam int CNT_W = $clog2(XLEN + 1);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mult_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MULT) |=> (state == ST_FINISH));

    p_result_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(dest_out));

    p_dz_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> done);

    p_div_count_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVIDE) |-> (cnt != '0 && cnt <= CNT_W'(XLEN)));

    p_busy_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && start) |=> (state == ST_IDLE));

endmodule

bind muldiv_unit muldiv_unit_chk #(.XLEN(XLEN)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .div_zero(div_zero),
    .dest_out(dest_out), .state(state_q), .cnt(cnt_q)
);

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [1:0]  size_code = '0;
    logic        use_imm = 1'b0;
    logic [63:0] src_a = '0, src_b = '0, dest_in = '0;
    logic [7:0]  imm = '0;
    logic [63:0] dest_out;
    logic        done, div_zero;

    int applied = 0;
    int fails = 0;

    muldiv_unit i_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .size_code(size_code), .use_imm(use_imm), .src_a(src_a), .src_b(src_b),
        .imm(imm), .dest_in(dest_in), .dest_out(dest_out), .done(done),
        .div_zero(div_zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference, evaluated from the requirements
    function automatic logic [63:0] ref_calc(input logic [2:0] op, input logic [1:0] sz,
                                             input logic [63:0] a, input logic [63:0] b,
                                             input logic [63:0] old, output logic dz,
                                             output int lat);
        int n, h;
        logic [127:0] fm, hm, am, bm, r;
        longint sa, sb, sp;
        n  = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
        h  = n / 2;
        fm = (128'd1 << n) - 128'd1;
        hm = (128'd1 << h) - 128'd1;
        am = {64'd0, a} & fm;
        bm = {64'd0, b} & fm;
        dz = 1'b0;
        lat = 1;
        r = '0;
        case (op)
            3'd0: r = (am & hm) * (bm & hm);
            3'd1: begin
                sa = longint'(am[63:0] << (64 - h)) >>> (64 - h);
                sb = longint'(bm[63:0] << (64 - h)) >>> (64 - h);
                sp = sa * sb;
                r  = {64'd0, sp};
            end
            3'd3: r = (((am & hm) * (bm >> h)) >> h) + (((am >> h) * (bm & hm)) >> h)
                      + (am >> h) * (bm >> h);
            3'd4, 3'd5, 3'd6: begin
                if (bm == 0) begin
                    dz = 1'b1;
                    lat = 0;
                    return old;
                end
                lat = n;
                if (op == 3'd4)      r = ((am / bm) & hm) | (((am % bm) & hm) << h);
                else if (op == 3'd5) r = am / bm;
                else                 r = am % bm;
            end
            default: r = am * bm;
        endcase
        return (old & ~fm[63:0]) | (r[63:0] & fm[63:0]);
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5, 3'd6: return "R7";
            default: return "R4";
        endcase
    endfunction

    bit          m_busy = 0;
    int          m_cnt = 0;
    logic [63:0] m_res = '0, m_old = '0, m_mask = '0;
    logic        m_dz = 1'b0;
    logic [2:0]  m_op = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
            m_cnt = 0;
        end else if (m_busy) begin
            if (m_cnt == 0) m_busy = 0;
            else m_cnt--;
        end else if (start) begin
            int lat;
            logic dz;
            m_res  = ref_calc(opcode, size_code, src_a, use_imm ? {56'd0, imm} : src_b,
                              dest_in, dz, lat);
            m_dz   = dz;
            m_cnt  = lat;
            m_op   = opcode;
            m_old  = dest_in;
            m_mask = (size_code == 2'd0) ? 64'hFFFF :
                     (size_code == 2'd1) ? 64'hFFFF_FFFF : '1;
            m_busy = 1;
        end
    end

    always @(negedge clk) begin
        applied++;
        if (!rst_n) begin
            if (done !== 1'b0 || div_zero !== 1'b0 || dest_out !== 64'd0) begin
                fails++;
                $display("FAIL R13 reset outputs: got done=%b dz=%b dest=%h expected 0 0 0",
                         done, div_zero, dest_out);
            end
        end else begin
            logic exp_done;
            exp_done = m_busy && (m_cnt == 0);
            if (done !== exp_done) begin
                fails++;
                $display("FAIL R9/R10/R12 done strobe: got %b expected %b", done, exp_done);
            end else if (exp_done) begin
                if (div_zero !== m_dz) begin
                    fails++;
                    $display("FAIL R11 div_zero: got %b expected %b", div_zero, m_dz);
                end
                if ((dest_out & ~m_mask) !== (m_old & ~m_mask)) begin
                    fails++;
                    $display("FAIL R8 upper bits: got %h expected %h",
                             dest_out & ~m_mask, m_old & ~m_mask);
                end
                if (dest_out !== m_res) begin
                    fails++;
                    $display("FAIL R1/%s result op%0d: got %h expected %h",
                             m_dz ? "R11" : tag_of(m_op), m_op, dest_out, m_res);
                end
            end else if (div_zero !== 1'b0) begin
                fails++;
                $display("FAIL R11 div_zero outside done: got %b expected 0", div_zero);
            end
        end
    end

    task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic [63:0] a,
                         input logic [63:0] b, input logic [7:0] im, input logic ui,
                         input logic [63:0] old, input bit extra);
        @(negedge clk);
        opcode = op; size_code = sz; src_a = a; src_b = b; imm = im;
        use_imm = ui; dest_in = old; start = 1'b1;
        @(negedge clk);
        if (extra) begin
            // R12: second request while busy, with different inputs
            src_a = ~a; src_b = b ^ 64'h5; dest_in = ~old; opcode = op ^ 3'd1;
            @(negedge clk);
        end
        start = 1'b0;
        while (m_busy) @(negedge clk);
    endtask

    function automatic logic [63:0] rnd64();
        logic [63:0] v;
        v = {$urandom, $urandom};
        case ($urandom % 6)
            0: v = '0;
            1: v = '1;
            2: v = v & 64'hFF;
            3: v = v | 64'h8000_8000_8000_8000;
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired: got hung run expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 unsigned half multiply, upper operand bits masked off (R1)
        issue(3'd0, 2'd0, 64'hABCD_0000_1234_00FF, 64'h0000_0000_0000_FF02, 8'h0, 1'b0, 64'h1111_2222_3333_4444, 0);
        // R3 signed half multiply with negative low halves
        issue(3'd1, 2'd0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0003, 8'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        issue(3'd1, 2'd1, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFE, 8'h0, 1'b0, 64'h0, 0);
        // R4 low product and its alias code
        issue(3'd2, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 8'h0, 1'b0, 64'h0, 0);
        issue(3'd7, 2'd1, 64'h0000_0000_1234_5678, 64'h0, 8'h9A, 1'b1, 64'hDEAD_BEEF_0000_0000, 0);
        // R5 high product
        issue(3'd3, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0, 1'b0, 64'h0, 0);
        issue(3'd3, 2'd0, 64'h0000_0000_0000_F00F, 64'h0000_0000_0000_8181, 8'h0, 1'b0, 64'h0123_4567_89AB_CDEF, 0);
        // R6 packed divide, R7 quotient and remainder at every size
        issue(3'd4, 2'd0, 64'h0000_0000_0000_FFFF, 64'h0, 8'h07, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 0);
        issue(3'd5, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 8'h0, 1'b0, 64'h0, 0);
        issue(3'd6, 2'd1, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_0010, 8'h0, 1'b0, 64'h5555_5555_0000_0000, 0);
        // R11 zero divisor: masked divisor is zero though src_b is not
        issue(3'd5, 2'd0, 64'h0000_0000_0000_1234, 64'hFFFF_FFFF_FFFF_0000, 8'h0, 1'b0, 64'hCAFE_F00D_1234_5678, 0);
        issue(3'd4, 2'd2, 64'h1, 64'h1, 8'h00, 1'b1, 64'h0F0F_0F0F_0F0F_0F0F, 1);
        // R12 extra start during busy for each latency class
        issue(3'd2, 2'd0, 64'h0000_0000_0000_0101, 64'h0000_0000_0000_0202, 8'h0, 1'b0, 64'h0, 1);
        issue(3'd6, 2'd0, 64'h0000_0000_0000_9999, 64'h0000_0000_0000_0033, 8'h0, 1'b0, 64'h0, 1);
        for (int i = 0; i < 400; i++) begin
            issue(3'($urandom % 8), 2'($urandom % 4), rnd64(), rnd64(), 8'($urandom),
                  1'($urandom % 3 == 0), rnd64(), bit'($urandom % 4 == 0));
        end
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule